// File: doc/BRIEF.md
# Page Write Collector with Timed Commit

This block sits behind the serial front end of a byte-wide non-volatile memory model. When a write command begins, the front end supplies the start address. Each received data byte is then presented with a one-cycle strobe. The block places the bytes into a page buffer of up to 64 slots. The page number is taken from the upper address bits and stays fixed. The slot index advances through the low address bits only, so a long burst wraps back to the start of the page and overwrites bytes it stored earlier.

Programming starts only when chip select is released at the right moment. The front end must report that the last bit clocked in closed a full byte. At least one data byte must have arrived. The protection logic must also allow the write. Once started, a self-timed programming window runs for a fixed number of clock ticks. During that window the block asserts busy and sweeps the page once, in ascending slot order. It issues one array write strobe for each slot that actually received a byte. When the window closes, a single-cycle pulse tells the status logic to drop the write-enable latch. While busy, every new start, data byte and chip-select release is ignored.

Top module: `pwb_top`

## Requirements
- R1: Each array write uses the page number latched from the upper bits of the start address (all bits above the low six), with the slot index as the low six bits. The first data byte goes to the slot given by the low six bits of the start address, and each further byte goes to the next slot.
- R2: After slot 63 the slot index wraps to slot 0 of the same page. A byte stored in a slot that was already filled replaces the earlier byte, and only the latest value is written.
- R3: Programming starts only when `cs_rise_i` is seen while a sequence is open, `byte_edge_i` is 1, `wr_ok_i` is 1 and at least one data byte has been stored. `busy_o` rises in the cycle after that clock edge.
- R4: A chip-select release with `byte_edge_i` at 0, with no stored byte, or with `wr_ok_i` at 0 discards the buffer. No busy, no array write and no completion pulse follow.
- R5: `busy_o` stays high for exactly `PROG_TICKS` consecutive cycles per programming window. `PROG_TICKS` must be at least the page size.
- R6: `wel_clr_o` is high for exactly one cycle: the first cycle after `busy_o` falls. It never appears without a programming window.
- R7: During the first 64 cycles of a window, one array write is issued per stored slot, in ascending slot order. Slots that received no byte are not written, and no array write occurs outside a window.
- R8: While `busy_o` is high, `seq_start_i`, `data_stb_i` and `cs_rise_i` have no effect. The page being written is not altered, and no second window follows.
- R9: After reset `busy_o`, `arr_we_o` and `wel_clr_o` are all 0, and no sequence is open.
- R10: Data strobes and chip-select releases that arrive when no sequence has been started are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seq_start_i | input | 1 | Opens a write sequence and latches `seq_addr_i` |
| seq_addr_i | input | ADDR_W | Start address of the sequence |
| data_stb_i | input | 1 | One-cycle strobe for a received data byte |
| data_i | input | 8 | Received data byte |
| byte_edge_i | input | 1 | 1 when the last bit clocked in completed a byte |
| cs_rise_i | input | 1 | One-cycle chip-select release event |
| wr_ok_i | input | 1 | Write permitted by the protection logic |
| busy_o | output | 1 | Programming window active |
| arr_we_o | output | 1 | Array byte write strobe |
| arr_addr_o | output | ADDR_W | Array byte address |
| arr_data_o | output | 8 | Array byte data |
| wel_clr_o | output | 1 | One-cycle pulse at the end of programming; clears the write-enable latch |

## Verification
The bench targets the following corner cases:
- A burst that starts two slots before the page end, which exposes a design that carries into the page number instead of wrapping to slot 0.
- A burst of 66 bytes, which catches a design that keeps the first value in a slot rather than the latest.
- Chip-select releases that are misaligned, that come before any byte, or that arrive without permission. A design that ignores one of these gates would start a window and emit writes the scoreboard never expected.
- A new full sequence driven while the block is busy, which exposes a design that re-arms, corrupts the page in flight, or runs a second window.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/pwb_collect.sv
module pwb_collect
  import pwb_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int PAGE_BYTES = 64,
  localparam int OFS_W     = $clog2(PAGE_BYTES),
  localparam int PAGE_W    = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              stb_i,
  input  byte_t             byte_i,
  input  logic              close_i,
  input  logic              keep_i,
  input  logic [OFS_W-1:0]  rd_slot_i,
  output byte_t             rd_byte_o,
  output logic [PAGE_BYTES-1:0] mask_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              open_o
);
  logic [OFS_W-1:0]      ofs_q;
  logic [PAGE_W-1:0]     page_q;
  logic [PAGE_BYTES-1:0] mask_q;
  logic                  open_q;
  byte_t                 buf_q [PAGE_BYTES];

  // in-page advance: only the low bits move, upper bits never touched
  function automatic logic [OFS_W-1:0] slot_after(input logic [OFS_W-1:0] s);
    return s + 1'b1;
  endfunction

  logic take_byte;
  assign take_byte = !hold_i && open_q && stb_i && !start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q  <= '0;
      page_q <= '0;
      mask_q <= '0;
      open_q <= 1'b0;
    end else if (!hold_i) begin
      if (start_i) begin
        open_q <= 1'b1;
        page_q <= start_addr_i[ADDR_W-1:OFS_W];
        ofs_q  <= start_addr_i[OFS_W-1:0];
        mask_q <= '0;
      end else if (take_byte) begin
        mask_q[ofs_q] <= 1'b1;
        ofs_q         <= slot_after(ofs_q);
      end
      if (close_i && open_q) begin
        open_q <= 1'b0;
        if (!keep_i) mask_q <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take_byte) buf_q[ofs_q] <= byte_i;
  end

  assign rd_byte_o = buf_q[rd_slot_i];
  assign mask_o    = mask_q;
  assign page_o    = page_q;
  assign open_o    = open_q;

  // R8: buffer contents bookkeeping frozen for the whole programming window
  p_frozen_in_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && $past(hold_i)) |-> ($stable(mask_q) && $stable(page_q)));

  // R2: the slot index wraps inside the page
  p_slot_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_byte && !close_i && (ofs_q == OFS_W'(PAGE_BYTES-1))) |=> (ofs_q == '0));

  // R10: no byte lands while no sequence is open
  p_closed_ignores_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_q && !start_i) |=> $stable(mask_q) || (mask_q == '0));
endmodule

// File: rtl/pwb_gate.sv
module pwb_gate #(
  parameter int PAGE_BYTES = 64
) (
  input  logic                  cs_rise_i,
  input  logic                  open_i,
  input  logic                  byte_edge_i,
  input  logic                  wr_ok_i,
  input  logic                  busy_i,
  input  logic [PAGE_BYTES-1:0] mask_i,
  output logic                  close_o,
  output logic                  commit_o
);
  logic any_byte;
  assign any_byte = |mask_i;
  assign close_o  = cs_rise_i && open_i && !busy_i;
  assign commit_o = close_o && byte_edge_i && wr_ok_i && any_byte;
endmodule

// File: rtl/pwb_timer.sv
module pwb_timer #(
  parameter int PAGE_BYTES = 64,
  parameter int PROG_TICKS = 200,
  localparam int OFS_W     = $clog2(PAGE_BYTES),
  localparam int CNT_W     = $clog2(PROG_TICKS) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  output logic             busy_o,
  output logic             sweep_o,
  output logic [OFS_W-1:0] slot_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] SWEEP_END = CNT_W'(PAGE_BYTES);
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(PROG_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             done_q;
  logic             at_end;
  assign at_end = busy_q && (cnt_q == LAST_TICK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (go_i) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
        end
      end else if (at_end) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign sweep_o = busy_q && (cnt_q < SWEEP_END);
  assign slot_o  = cnt_q[OFS_W-1:0];

  // R6: completion pulse lasts one cycle
  p_done_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R6: pulse coincides with the first idle cycle
  p_done_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);
  // R5: the tick count never exceeds the window length
  p_window_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= LAST_TICK));
endmodule

// File: rtl/pwb_top.sv
module pwb_top
  import pwb_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int PAGE_BYTES = 64,
  parameter int PROG_TICKS = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_start_i,
  input  logic [ADDR_W-1:0] seq_addr_i,
  input  logic              data_stb_i,
  input  logic [7:0]        data_i,
  input  logic              byte_edge_i,
  input  logic              cs_rise_i,
  input  logic              wr_ok_i,
  output logic              busy_o,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [7:0]        arr_data_o,
  output logic              wel_clr_o
);
  localparam int OFS_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFS_W;

  logic                  busy_w, sweep_w, done_w;
  logic                  close_w, commit_w, open_w;
  logic [OFS_W-1:0]      slot_w;
  logic [PAGE_BYTES-1:0] mask_w;
  logic [PAGE_W-1:0]     page_w;
  byte_t                 rd_byte_w;

  pwb_collect #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_collect (
    .clk(clk), .rst_n(rst_n), .hold_i(busy_w),
    .start_i(seq_start_i), .start_addr_i(seq_addr_i),
    .stb_i(data_stb_i), .byte_i(data_i),
    .close_i(close_w), .keep_i(commit_w),
    .rd_slot_i(slot_w), .rd_byte_o(rd_byte_w),
    .mask_o(mask_w), .page_o(page_w), .open_o(open_w)
  );

  pwb_gate #(.PAGE_BYTES(PAGE_BYTES)) u_gate (
    .cs_rise_i(cs_rise_i), .open_i(open_w), .byte_edge_i(byte_edge_i),
    .wr_ok_i(wr_ok_i), .busy_i(busy_w), .mask_i(mask_w),
    .close_o(close_w), .commit_o(commit_w)
  );

  pwb_timer #(.PAGE_BYTES(PAGE_BYTES), .PROG_TICKS(PROG_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .go_i(commit_w),
    .busy_o(busy_w), .sweep_o(sweep_w), .slot_o(slot_w), .done_o(done_w)
  );

  assign busy_o     = busy_w;
  assign arr_we_o   = sweep_w && mask_w[slot_w];
  assign arr_addr_o = {page_w, slot_w};
  assign arr_data_o = rd_byte_w;
  assign wel_clr_o  = done_w;

  // R7: array writes happen only inside a window
  p_write_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we_o |-> busy_o);
  // R3: a window opens only after a gated release
  p_start_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(cs_rise_i && byte_edge_i && wr_ok_i));
  // R4: a misaligned release never opens a window
  p_misaligned_no_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise_i && !byte_edge_i && !busy_o) |=> !busy_o);
  // R1: consecutive writes in a window stay on one page
  p_same_page_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we_o && $past(arr_we_o)) |->
      (arr_addr_o[ADDR_W-1:OFS_W] == $past(arr_addr_o[ADDR_W-1:OFS_W])));
endmodule

// File: tb/pwb_top_test.sv
module pwb_top_test;
  localparam int AW    = 15;
  localparam int TICKS = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seq_start = 0, data_stb = 0, byte_edge = 0, cs_rise = 0, wr_ok = 0;
  logic [AW-1:0] seq_addr = '0;
  logic [7:0] data = '0;
  logic busy, we, wel_clr;
  logic [AW-1:0] waddr;
  logic [7:0] wdata;

  always #5 clk = ~clk;

  pwb_top #(.ADDR_W(AW), .PAGE_BYTES(64), .PROG_TICKS(TICKS)) uut (
    .clk(clk), .rst_n(rst_n), .seq_start_i(seq_start), .seq_addr_i(seq_addr),
    .data_stb_i(data_stb), .data_i(data), .byte_edge_i(byte_edge),
    .cs_rise_i(cs_rise), .wr_ok_i(wr_ok), .busy_o(busy), .arr_we_o(we),
    .arr_addr_o(waddr), .arr_data_o(wdata), .wel_clr_o(wel_clr)
  );

  int checks = 0, fails = 0, exp_done = 0, seen_done = 0;
  bit finished = 0;
  logic [AW+7:0] exp_q [$];

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic tick; @(posedge clk); #1; endtask

  // scoreboard driver side: reference page image, pushed in ascending slot order
  task automatic expect_page(input logic [AW-1:0] a, input int n, input int base);
    logic [7:0] img [64];
    bit         vld [64];
    int pos;
    for (int s = 0; s < 64; s++) vld[s] = 0;
    pos = a % 64;
    for (int i = 0; i < n; i++) begin
      img[pos] = 8'(base + i);
      vld[pos] = 1;
      pos = (pos + 1) % 64;
    end
    for (int s = 0; s < 64; s++)
      if (vld[s]) exp_q.push_back({(a / 64) * 64 + s, img[s]});
    exp_done++;
  endtask

  task automatic start_seq(input logic [AW-1:0] a);
    seq_start = 1; seq_addr = a; tick; seq_start = 0;
  endtask

  task automatic send(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      data_stb = 1; data = 8'(base + i); tick;
    end
    data_stb = 0;
  endtask

  task automatic release_cs(input bit aligned, input bit ok);
    byte_edge = aligned; wr_ok = ok; cs_rise = 1; tick;
    cs_rise = 0; byte_edge = 0; wr_ok = 0;
  endtask

  task automatic wait_idle;
    @(negedge clk);
    while (busy) @(negedge clk);
    tick; tick;
  endtask

  task automatic check_quiet(input string req);
    repeat (6) @(negedge clk);
    chk(busy == 0, req, busy, 0);
    tick;
  endtask

  // scoreboard monitor side
  int  run = 0;
  bit  prev_busy = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (we) begin
        if (exp_q.size() == 0) chk(0, "R7 unexpected write", waddr, 0);
        else begin
          logic [AW+7:0] e;
          e = exp_q.pop_front();
          chk({waddr, wdata} == e, "R1/R2/R7 write addr,data", {waddr, wdata}, e);
        end
      end
      if (busy) run++;
      if (prev_busy && !busy) begin
        chk(run == TICKS, "R5 busy length", run, TICKS);
        chk(wel_clr == 1, "R6 pulse after busy", wel_clr, 1);
        run = 0;
      end else if (wel_clr) chk(0, "R6 stray pulse", 1, 0);
      if (wel_clr) seen_done++;
      prev_busy = busy;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && we == 0 && wel_clr == 0, "R9 reset outputs", {busy, we, wel_clr}, 0);
    @(posedge clk); #1 rst_n = 1;
    tick;
    chk(busy == 0, "R9 idle after reset", busy, 0);

    // R1 R3 R7: short burst mid page
    expect_page(15'h1234, 3, 8'h10);
    start_seq(15'h1234); send(3, 8'h10); release_cs(1, 1);
    wait_idle;

    // R1: burst across page end wraps inside the page
    expect_page(15'h07FE, 4, 8'hA0);
    start_seq(15'h07FE); send(4, 8'hA0); release_cs(1, 1);
    wait_idle;

    // R2: 66 bytes, two earliest slots overwritten
    expect_page(15'h2A50, 66, 8'h01);
    start_seq(15'h2A50); send(66, 8'h01); release_cs(1, 1);
    wait_idle;

    // R4: misaligned release
    start_seq(15'h0300); send(2, 8'h55); release_cs(0, 1);
    check_quiet("R4 misaligned");
    // R10: later aligned release with no open sequence
    release_cs(1, 1);
    check_quiet("R10 release without sequence");

    // R4: no data bytes
    start_seq(15'h0400); release_cs(1, 1);
    check_quiet("R4 no bytes");

    // R4: protection refuses
    start_seq(15'h0500); send(3, 8'h77); release_cs(1, 0);
    check_quiet("R4 not permitted");

    // R10: bytes with no start
    send(2, 8'h33); release_cs(1, 1);
    check_quiet("R10 bytes without start");

    // R8: full sequence driven during a window is ignored
    expect_page(15'h3FC0, 5, 8'hC0);
    start_seq(15'h3FC0); send(5, 8'hC0); release_cs(1, 1);
    start_seq(15'h0100); send(3, 8'hEE); release_cs(1, 1);
    wait_idle;
    check_quiet("R8 no second window");

    tick; tick;
    chk(exp_q.size() == 0, "R7 all expected writes seen", exp_q.size(), 0);
    chk(seen_done == exp_done, "R6 pulse count", seen_done, exp_done);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule